// File: doc/BRIEF.md
# Compact 16-bit instruction decoder

This block turns one 16-bit instruction word of a 32-register load/store machine into the fields and control signals an execution pipeline needs. It is purely combinational: the word and the address it was fetched from go in, and in the same cycle out come the opcode, both register indices, a 32-bit immediate, a PC-relative target and a set of control codes. These codes cover the operation class, the ALU operation, the memory access width and signedness, and the branch condition. An illegal flag marks any word that does not decode.

Three layouts share the word. A short layout has a 3-bit major code in the top bits and is used by the two immediate loads. A standard layout has a 6-bit opcode, a register a and a register b or 5-bit immediate. A wide layout has a 6-bit opcode and a 10-bit immediate. The short layout takes up the top quarter of the 6-bit opcode space, so opcodes 0x30 to 0x3F never occur as standard opcodes. In the branch and ALU ranges, opcode bit 3 picks the immediate variant of an operation. Register access, execution and memory traffic are handled elsewhere.

The block has no states. Its single evaluation path runs from the word through format classification (standard, short, wide) to control and immediate generation. There are no transitions.

Top module: `idec16_top`

## Requirements
- R1: `fmt` is 1 (short) when bits [15:14] are 11. It is 2 (wide) for opcodes 0x0E and 0x1E. It is 0 (standard) for every other word.
- R2: `opc` always equals bits [15:10] and `rb` always equals bits [4:0]. `ra` is bits [12:8] in the short layout and bits [9:5] otherwise.
- R3: Top bits 110 give class 1 (load immediate), `use_imm`=1 and `imm32` = bits [7:0] sign-extended.
- R4: Top bits 111 give class 2 (PC-relative load), `use_imm`=1, `imm32` = bits [7:0] sign-extended, `tgt_vld`=1 and `target` = pc + 4*imm32.
- R5: Opcode 0x00 is illegal, and so is the all-zero word. Opcode 0x01 is legal only as the exact word 0x0400, which gives class 10. Opcode 0x0F is legal only when bits [9:5] are zero. An illegal word gives `illegal`=1, class 0 and idle controls (see R11).
- R6: Opcodes 0x02 to 0x09 give class 3 (load) or class 4 (store). Stores are 0x03, 0x05 and 0x07. `mem_size` (0 byte, 1 half, 2 word) is 2 for 0x02 and 0x03, 1 for 0x04, 0x05 and 0x08, and 0 for 0x06, 0x07 and 0x09. `mem_signed`=1 only for 0x08 and 0x09.
- R7: 0x0A gives class 5 (push) and 0x0B gives class 6 (pop), both with `mem_size`=2. 0x0C gives class 7 (machine register to ra) and 0x0D gives class 8 (ra to machine register). 0x0E and a legal 0x0F give class 9 (syscall). 0x0E also sets `use_imm`=1 with `imm32` = bits [9:0] zero-extended.
- R8: Opcodes 0x10 to 0x15 and 0x18 to 0x1D give class 11 (branch) with `br_cond` = opcode bits [2:0] (0 zero, 1 nonzero, 2 less, 3 greater, 4 less-or-equal, 5 greater-or-equal). The 0x18 group also sets `use_imm`=1, `imm32` = bits [4:0] sign-extended, `tgt_vld`=1 and `target` = pc + 2*imm32.
- R9: 0x16 and 0x1E give class 12 (jump). 0x17 and 0x1F give class 13 (call). All four set `br_cond`=6 (always). 0x1E uses bits [9:0] sign-extended and 0x1F uses bits [4:0] sign-extended. Both set `use_imm`=1, `tgt_vld`=1 and `target` = pc + 2*imm32.
- R10: 0x20 to 0x2F give class 14 (ALU) with `alu_op` 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not, 6 shl, 7 shr, 8 mul, 9 div, 10 mov. Opcodes 0x20 to 0x27 take codes 0 to 7 in order. 0x28, 0x29, 0x2A, 0x2E and 0x2F are the add, sub, and, shl and shr immediate forms: each sets `use_imm`=1 with `imm32` = bits [4:0] zero-extended. 0x2B, 0x2C and 0x2D are mul, div and mov with no immediate.
- R11: Any output that does not apply to the decoded class stays idle: `alu_op`=15, `br_cond`=7, `mem_size`=0, `mem_signed`=0, `use_imm`=0, `imm32`=0 and `tgt_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| pc | input | 32 | Address of the instruction |
| fmt | output | 2 | Layout: 0 standard, 1 short, 2 wide |
| opc | output | 6 | Bits [15:10] |
| ra | output | 5 | Destination / first register index |
| rb | output | 5 | Second register index (bits [4:0]) |
| imm32 | output | 32 | Extended immediate |
| use_imm | output | 1 | Operation uses `imm32` |
| op_class | output | 4 | Operation class code |
| alu_op | output | 4 | ALU operation code |
| mem_size | output | 2 | Access width: 0 byte, 1 half, 2 word |
| mem_signed | output | 1 | Load result is sign-extended |
| br_cond | output | 3 | Branch condition code |
| target | output | 32 | PC-relative address |
| tgt_vld | output | 1 | `target` is meaningful |
| illegal | output | 1 | Word does not decode |

## Verification
All 65,536 words are applied, each with a different scrambled PC, and every output is compared with a behavioural model. Because the sweep is exhaustive, it separates the short layout from the 0x30 to 0x3F standard codes that it replaces, and it checks the strict words for RETI and register SYSCALL against every one of their near misses. It also shows that bit 3 switches only those branch and ALU opcodes that actually have an immediate form. The varied PCs exercise the target adders with both signs of displacement and with carries across the upper bits, and they separate the scale of 4 used by the PC-relative load from the scale of 2 used by branches.

// File: rtl/idec16_pkg.sv
package idec16_pkg;

    typedef enum logic [1:0] {
        FMT_STD   = 2'd0,
        FMT_SHORT = 2'd1,
        FMT_WIDE  = 2'd2
    } fmt_e;

    typedef enum logic [3:0] {
        CLS_ILL     = 4'd0,
        CLS_LDI     = 4'd1,
        CLS_LDPC    = 4'd2,
        CLS_LOAD    = 4'd3,
        CLS_STORE   = 4'd4,
        CLS_PUSH    = 4'd5,
        CLS_POP     = 4'd6,
        CLS_MREG_RD = 4'd7,
        CLS_MREG_WR = 4'd8,
        CLS_SYS     = 4'd9,
        CLS_RETI    = 4'd10,
        CLS_BRANCH  = 4'd11,
        CLS_JUMP    = 4'd12,
        CLS_CALL    = 4'd13,
        CLS_ALU     = 4'd14
    } cls_e;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_AND  = 4'd2,
        ALU_OR   = 4'd3,
        ALU_XOR  = 4'd4,
        ALU_NOT  = 4'd5,
        ALU_SHL  = 4'd6,
        ALU_SHR  = 4'd7,
        ALU_MUL  = 4'd8,
        ALU_DIV  = 4'd9,
        ALU_MOV  = 4'd10,
        ALU_NONE = 4'd15
    } alu_e;

    typedef enum logic [2:0] {
        BRC_Z      = 3'd0,
        BRC_NZ     = 3'd1,
        BRC_LT     = 3'd2,
        BRC_GT     = 3'd3,
        BRC_LE     = 3'd4,
        BRC_GE     = 3'd5,
        BRC_ALWAYS = 3'd6,
        BRC_NONE   = 3'd7
    } brc_e;

    typedef enum logic [1:0] {
        MSZ_BYTE = 2'd0,
        MSZ_HALF = 2'd1,
        MSZ_WORD = 2'd2
    } msz_e;

endpackage

// File: rtl/idec16_class.sv
module idec16_class
    import idec16_pkg::*;
(
    input  logic [15:0] instr,
    output logic [5:0]  opc,
    output fmt_e        fmt,
    output cls_e        cls,
    output logic        ill
);

    always_comb begin
        opc = instr[15:10];
        fmt = FMT_STD;
        cls = CLS_ILL;
        ill = 1'b0;
        if (instr[15:14] == 2'b11) begin
            fmt = FMT_SHORT;
            cls = instr[13] ? CLS_LDPC : CLS_LDI;
        end else begin
            case (opc) inside
                6'h00: ill = 1'b1;
                6'h01: begin
                    if (instr[9:0] == 10'd0) cls = CLS_RETI;
                    else                     ill = 1'b1;
                end
                [6'h02:6'h09]: begin
                    cls = (opc inside {6'h03, 6'h05, 6'h07}) ? CLS_STORE : CLS_LOAD;
                end
                6'h0A: cls = CLS_PUSH;
                6'h0B: cls = CLS_POP;
                6'h0C: cls = CLS_MREG_RD;
                6'h0D: cls = CLS_MREG_WR;
                6'h0E: begin
                    cls = CLS_SYS;
                    fmt = FMT_WIDE;
                end
                6'h0F: begin
                    if (instr[9:5] == 5'd0) cls = CLS_SYS;
                    else                    ill = 1'b1;
                end
                [6'h10:6'h1F]: begin
                    case (opc[2:0])
                        3'd6: begin
                            cls = CLS_JUMP;
                            if (opc[3]) fmt = FMT_WIDE;
                        end
                        3'd7:    cls = CLS_CALL;
                        default: cls = CLS_BRANCH;
                    endcase
                end
                default: cls = CLS_ALU;
            endcase
        end
    end

    // R5
    always_comb begin
        zero_word_ill_chk: assert (instr != 16'h0000 || ill)
            else $error("all-zero word decoded as legal");
    end

    // R1
    always_comb begin
        short_fmt_chk: assert (instr[15:14] != 2'b11 || (fmt == FMT_SHORT && !ill))
            else $error("short layout not recognised");
    end

endmodule

// File: rtl/idec16_ctrl.sv
module idec16_ctrl
    import idec16_pkg::*;
(
    input  logic [5:0] opc,
    input  cls_e       cls,
    output alu_e       alu,
    output logic       alu_imm,
    output msz_e       msz,
    output logic       msg,
    output brc_e       brc
);

    always_comb begin
        alu     = ALU_NONE;
        alu_imm = 1'b0;
        msz     = MSZ_BYTE;
        msg     = 1'b0;
        brc     = BRC_NONE;
        case (cls)
            CLS_LOAD, CLS_STORE: begin
                case (opc)
                    6'h02, 6'h03:        msz = MSZ_WORD;
                    6'h04, 6'h05, 6'h08: msz = MSZ_HALF;
                    default:             msz = MSZ_BYTE;
                endcase
                msg = (opc == 6'h08) || (opc == 6'h09);
            end
            CLS_PUSH, CLS_POP: msz = MSZ_WORD;
            CLS_BRANCH:        brc = brc_e'(opc[2:0]);
            CLS_JUMP, CLS_CALL: brc = BRC_ALWAYS;
            CLS_ALU: begin
                if (opc[3]) begin
                    case (opc[2:0])
                        3'd3: alu = ALU_MUL;
                        3'd4: alu = ALU_DIV;
                        3'd5: alu = ALU_MOV;
                        default: begin
                            alu     = alu_e'({1'b0, opc[2:0]});
                            alu_imm = 1'b1;
                        end
                    endcase
                end else begin
                    alu = alu_e'({1'b0, opc[2:0]});
                end
            end
            default: ;
        endcase
    end

    // R6
    always_comb begin
        signed_load_chk: assert (!msg || (cls == CLS_LOAD && msz != MSZ_WORD))
            else $error("signed extension outside narrow load");
    end

    // R11
    always_comb begin
        alu_br_excl_chk: assert (alu == ALU_NONE || brc == BRC_NONE)
            else $error("ALU and branch codes both active");
    end

endmodule

// File: rtl/idec16_imm.sv
module idec16_imm
    import idec16_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [15:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  cls_e            cls,
    input  logic            alu_imm,
    output logic [XLEN-1:0] imm32,
    output logic            use_imm,
    output logic [XLEN-1:0] target,
    output logic            tgt_vld
);

    logic [XLEN-1:0] sx8, sx10, sx5, zx10, zx5;
    logic            scale4;

    assign sx8  = {{(XLEN-8){instr[7]}}, instr[7:0]};
    assign sx10 = {{(XLEN-10){instr[9]}}, instr[9:0]};
    assign sx5  = {{(XLEN-5){instr[4]}}, instr[4:0]};
    assign zx10 = {{(XLEN-10){1'b0}}, instr[9:0]};
    assign zx5  = {{(XLEN-5){1'b0}}, instr[4:0]};

    always_comb begin
        imm32   = '0;
        use_imm = 1'b0;
        tgt_vld = 1'b0;
        scale4  = 1'b0;
        case (cls)
            CLS_LDI: begin
                imm32   = sx8;
                use_imm = 1'b1;
            end
            CLS_LDPC: begin
                imm32   = sx8;
                use_imm = 1'b1;
                tgt_vld = 1'b1;
                scale4  = 1'b1;
            end
            CLS_SYS: begin
                if (!instr[10]) begin
                    imm32   = zx10;
                    use_imm = 1'b1;
                end
            end
            CLS_BRANCH, CLS_CALL: begin
                if (instr[13]) begin
                    imm32   = sx5;
                    use_imm = 1'b1;
                    tgt_vld = 1'b1;
                end
            end
            CLS_JUMP: begin
                if (instr[13]) begin
                    imm32   = sx10;
                    use_imm = 1'b1;
                    tgt_vld = 1'b1;
                end
            end
            CLS_ALU: begin
                if (alu_imm) begin
                    imm32   = zx5;
                    use_imm = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign target = pc + (scale4 ? (imm32 << 2) : (imm32 << 1));

    // R4
    always_comb begin
        ldpc_align_chk: assert (!(tgt_vld && cls == CLS_LDPC) || ((target - pc) & 32'd3) == 32'd0)
            else $error("PC-relative load offset not a multiple of 4");
    end

    // R9
    always_comb begin
        tgt_needs_imm_chk: assert (!tgt_vld || use_imm)
            else $error("target valid without immediate");
    end

endmodule

// File: rtl/idec16_top.sv
module idec16_top
    import idec16_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic [15:0]     instr,
    input  logic [XLEN-1:0] pc,
    output logic [1:0]      fmt,
    output logic [5:0]      opc,
    output logic [RW-1:0]   ra,
    output logic [RW-1:0]   rb,
    output logic [XLEN-1:0] imm32,
    output logic            use_imm,
    output logic [3:0]      op_class,
    output logic [3:0]      alu_op,
    output logic [1:0]      mem_size,
    output logic            mem_signed,
    output logic [2:0]      br_cond,
    output logic [XLEN-1:0] target,
    output logic            tgt_vld,
    output logic            illegal
);

    localparam int RW = $clog2(NREG);

    fmt_e fmt_w;
    cls_e cls_w;
    alu_e alu_w;
    msz_e msz_w;
    brc_e brc_w;
    logic alu_imm_w;
    logic msg_w;

    idec16_class u_class (
        .instr (instr),
        .opc   (opc),
        .fmt   (fmt_w),
        .cls   (cls_w),
        .ill   (illegal)
    );

    idec16_ctrl u_ctrl (
        .opc     (opc),
        .cls     (cls_w),
        .alu     (alu_w),
        .alu_imm (alu_imm_w),
        .msz     (msz_w),
        .msg     (msg_w),
        .brc     (brc_w)
    );

    idec16_imm #(.XLEN(XLEN)) u_imm (
        .instr   (instr),
        .pc      (pc),
        .cls     (cls_w),
        .alu_imm (alu_imm_w),
        .imm32   (imm32),
        .use_imm (use_imm),
        .target  (target),
        .tgt_vld (tgt_vld)
    );

    assign fmt        = fmt_w;
    assign op_class   = cls_w;
    assign alu_op     = alu_w;
    assign mem_size   = msz_w;
    assign mem_signed = msg_w;
    assign br_cond    = brc_w;
    assign ra         = (fmt_w == FMT_SHORT) ? instr[8+RW-1:8] : instr[5+RW-1:5];
    assign rb         = instr[RW-1:0];

    // R5
    always_comb begin
        ill_idle_chk: assert (!illegal || (!use_imm && !tgt_vld && alu_w == ALU_NONE
                                           && brc_w == BRC_NONE && msz_w == MSZ_BYTE))
            else $error("illegal word left controls active");
    end

    // R2
    always_comb begin
        ra_field_chk: assert (fmt_w == FMT_SHORT || ra == instr[9:5])
            else $error("register a field misplaced");
    end

endmodule

// File: tb/idec16_top_tb_top.sv
module idec16_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] instr = 16'h0000;
    logic [31:0] pc = 32'h0;
    logic [1:0]  fmt;
    logic [5:0]  opc;
    logic [4:0]  ra, rb;
    logic [31:0] imm32, target;
    logic        use_imm, mem_signed, tgt_vld, illegal;
    logic [3:0]  op_class, alu_op;
    logic [1:0]  mem_size;
    logic [2:0]  br_cond;

    idec16_top dut_i (
        .instr(instr), .pc(pc), .fmt(fmt), .opc(opc), .ra(ra), .rb(rb),
        .imm32(imm32), .use_imm(use_imm), .op_class(op_class), .alu_op(alu_op),
        .mem_size(mem_size), .mem_signed(mem_signed), .br_cond(br_cond),
        .target(target), .tgt_vld(tgt_vld), .illegal(illegal)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic [5:0]  opc;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] imm;
        logic        use_imm;
        logic [3:0]  cls;
        logic [3:0]  alu;
        logic [1:0]  msz;
        logic        msg;
        logic [2:0]  br;
        logic        tv;
        logic [31:0] tgt;
        logic        ill;
    } exp_t;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    function automatic exp_t ref_decode(input logic [15:0] w, input logic [31:0] p);
        exp_t e;
        int op, k;
        bit immf;
        e = '0;
        e.opc = w[15:10]; e.ra = w[9:5]; e.rb = w[4:0];
        e.alu = 4'd15; e.br = 3'd7;
        op = int'(w[15:10]);
        if (op >= 48) begin
            e.fmt = 2'd1; e.ra = w[12:8];
            e.imm = {{24{w[7]}}, w[7:0]}; e.use_imm = 1'b1;
            if (w[13]) begin
                e.cls = 4'd2; e.tv = 1'b1; e.tgt = p + e.imm * 32'd4;
            end else e.cls = 4'd1;
        end else if (op == 0) e.ill = 1'b1;
        else if (op == 1) begin
            if (w == 16'h0400) e.cls = 4'd10; else e.ill = 1'b1;
        end else if (op <= 9) begin
            e.cls = (op == 3 || op == 5 || op == 7) ? 4'd4 : 4'd3;
            if (op == 2 || op == 3) e.msz = 2'd2;
            else if (op == 4 || op == 5 || op == 8) e.msz = 2'd1;
            else e.msz = 2'd0;
            e.msg = (op == 8 || op == 9);
        end else if (op == 10) begin e.cls = 4'd5; e.msz = 2'd2; end
        else if (op == 11) begin e.cls = 4'd6; e.msz = 2'd2; end
        else if (op == 12) e.cls = 4'd7;
        else if (op == 13) e.cls = 4'd8;
        else if (op == 14) begin
            e.fmt = 2'd2; e.cls = 4'd9; e.use_imm = 1'b1; e.imm = {22'd0, w[9:0]};
        end else if (op == 15) begin
            if (w[9:5] == 5'd0) e.cls = 4'd9; else e.ill = 1'b1;
        end else if (op < 32) begin
            immf = (op >= 24);
            k = (op - 16) % 8;
            if (k < 6) begin
                e.cls = 4'd11; e.br = 3'(k);
                if (immf) begin
                    e.imm = {{27{w[4]}}, w[4:0]}; e.use_imm = 1'b1; e.tv = 1'b1;
                    e.tgt = p + e.imm * 32'd2;
                end
            end else begin
                e.cls = (k == 6) ? 4'd12 : 4'd13; e.br = 3'd6;
                if (immf) begin
                    if (k == 6) begin
                        e.fmt = 2'd2; e.imm = {{22{w[9]}}, w[9:0]};
                    end else e.imm = {{27{w[4]}}, w[4:0]};
                    e.use_imm = 1'b1; e.tv = 1'b1; e.tgt = p + e.imm * 32'd2;
                end
            end
        end else begin
            e.cls = 4'd14;
            case (op)
                40: e.alu = 4'd0;  41: e.alu = 4'd1;  42: e.alu = 4'd2;
                43: e.alu = 4'd8;  44: e.alu = 4'd9;  45: e.alu = 4'd10;
                46: e.alu = 4'd6;  47: e.alu = 4'd7;
                default: e.alu = 4'(op - 32);
            endcase
            if (op == 40 || op == 41 || op == 42 || op == 46 || op == 47) begin
                e.use_imm = 1'b1; e.imm = {27'd0, w[4:0]};
            end
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4: return "R6";
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return "R7";
            4'd11: return "R8";
            4'd12, 4'd13: return "R9";
            4'd14: return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s instr=%h act=%h exp=%h", tag, what, instr, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        string t;
        t = tag_of(e.cls);
        chk("R1", "fmt", 32'(fmt), 32'(e.fmt));
        chk("R2", "opc", 32'(opc), 32'(e.opc));
        chk("R2", "ra", 32'(ra), 32'(e.ra));
        chk("R2", "rb", 32'(rb), 32'(e.rb));
        chk("R5", "illegal", 32'(illegal), 32'(e.ill));
        chk(t, "class", 32'(op_class), 32'(e.cls));
        chk(e.use_imm ? t : "R11", "imm32", imm32, e.imm);
        chk(e.use_imm ? t : "R11", "use_imm", 32'(use_imm), 32'(e.use_imm));
        chk(e.cls == 4'd14 ? "R10" : "R11", "alu_op", 32'(alu_op), 32'(e.alu));
        chk(e.br != 3'd7 ? t : "R11", "br_cond", 32'(br_cond), 32'(e.br));
        chk(e.msz != 2'd0 || e.cls == 4'd3 || e.cls == 4'd4 ? "R6" : "R11",
            "mem_size", 32'(mem_size), 32'(e.msz));
        chk(e.msg ? "R6" : "R11", "mem_signed", 32'(mem_signed), 32'(e.msg));
        chk(e.tv ? t : "R11", "tgt_vld", 32'(tgt_vld), 32'(e.tv));
        if (e.tv) chk(t, "target", target, e.tgt);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: all-zero word is illegal (R5)
        chk("R5", "reset illegal", 32'(illegal), 32'd1);
        chk("R11", "reset use_imm", 32'(use_imm), 32'd0);
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            instr = 16'(i);
            pc = 32'h1000_0000 ^ (32'(i) * 32'h9E37_79B9);
            @(posedge clk);
            #1;
            compare(ref_decode(instr, pc));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule